// File: doc/BRIEF.md
# PHY Management Access Register

This block puts one 32-bit command/status word in front of a clause-22 serial management link (MDC clock, MDIO data). Software writes a command word: bit 31 selects the direction (1 asks for a PHY register write, 0 for a PHY register read), bits 23:16 name the PHY register and bits 15:0 carry the write data. The block then produces a complete 64-bit management frame on MDC/MDIO. The frame contains a 32-bit preamble of ones, start `01`, opcode, a fixed PHY address, the register number, turnaround and 16 data bits sent MSB first.

Bit 31 works in opposite senses for the two directions, so one polling loop cannot serve both. A write command leaves the bit at 1, and the block clears it once the last data bit has been clocked out. A read command leaves the bit at 0, and the block sets it once the 16 returned bits sit in bits 15:0. MDC is the system clock divided by an even parameter. The block changes MDIO only while MDC is low and samples returned data on the MDC rising edge. The host side is a plain register port with write enable, address and data, plus a read-data bus that always shows the word. There is no back-pressure. The block drops a command written while a frame is running, so software has to wait for bit 31 to flip before it issues the next one.

Top module: `phy_mgmt_reg`

## Requirements
- R1: While reset is asserted and after it is released, the word reads 0x00000000, MDC is low and MDIO is not driven (`mdio_oe` = 0).
- R2: A write at offset `REG_OFFSET` with bit 31 = 1 is accepted when idle. The word reads back as written with bit 31 = 1 until the frame ends. Bit 31 then reads 0 exactly 2 + 63·`CLK_DIV` + `CLK_DIV`/2 clock cycles after the accepting edge.
- R3: A write frame drives 64 bits in this order: 32 ones, `01`, opcode `01`, `PHY_ADDR` (5 bits, MSB first), bits 20:16 of the command (MSB first), turnaround `10`, then bits 15:0 MSB first. `mdio_oe` stays 1 for all 64 bits.
- R4: A read frame drives the first 46 bits (preamble, `01`, opcode `10`, PHY address, register number) and releases MDIO (`mdio_oe` = 0) for the 2 turnaround bits and the 16 data bits.
- R5: When a read ends, bit 31 reads 1 and bits 15:0 hold the 16 MDIO bits sampled at the MDC rising edges of frame bits 48..63, first sampled bit in bit 15. Completion timing is as in R2.
- R6: MDC has a period of `CLK_DIV` clock cycles (low half first) while a frame runs. `mdio_o` and `mdio_oe` change only while MDC is low.
- R7: A write enable with `reg_addr` different from `REG_OFFSET` has no effect: the word is unchanged and no frame starts.
- R8: A write at `REG_OFFSET` while a frame is running is ignored. The word, the running frame and its completion time stay as set by the first command.
- R9: Whenever no access is running, MDC is low and `mdio_oe` is 0.
- R10: Only bits 20:16 of the command reach the wire as the register number. Bits 30:24 and 23:21 have no effect on the frame but read back as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Byte offset of the write |
| reg_wdata | input | 32 | Command word |
| reg_rdata | output | 32 | Current value of the command/status word |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Management data out |
| mdio_oe | output | 1 | Management data output enable |
| mdio_i | input | 1 | Management data in |

## Verification
The bench builds the block with `CLK_DIV` = 4 and `PHY_ADDR` = 5'h1D. The short divider brings a whole 64-bit frame down to 256 clock cycles, so six table-driven accesses and the directed cases finish quickly. It still leaves two cycles in each MDC half, which is enough to check that data only moves while MDC is low. The non-default PHY address with mixed ones and zeros shows that the address field is placed and ordered correctly. It would not be visible with the default value 1.

// File: rtl/mdio_acc_pkg.sv
package mdio_acc_pkg;

  localparam int FRAME_BITS   = 64;
  localparam int POS_W        = $clog2(FRAME_BITS);
  localparam int CNT_W        = POS_W + 1;
  localparam int DATA_W       = 16;
  localparam int REGNUM_W     = 5;
  localparam int PHYNUM_W     = 5;
  localparam int RD_DRIVE_BITS = 46;
  localparam int DATA_FIRST   = FRAME_BITS - DATA_W;

  localparam logic [1:0] START_SEQ = 2'b01;
  localparam logic [1:0] OP_WR     = 2'b01;
  localparam logic [1:0] OP_RD     = 2'b10;
  localparam logic [1:0] TA_WR     = 2'b10;

  function automatic logic [FRAME_BITS-1:0] build_frame(
    input logic                wr,
    input logic [PHYNUM_W-1:0] phy,
    input logic [REGNUM_W-1:0] regnum,
    input logic [DATA_W-1:0]   wdata
  );
    build_frame = {{32{1'b1}}, START_SEQ, (wr ? OP_WR : OP_RD), phy, regnum,
                   (wr ? TA_WR : 2'b11), (wr ? wdata : {DATA_W{1'b1}})};
  endfunction

endpackage

// File: rtl/mdc_gen.sv
module mdc_gen #(
  parameter int unsigned CLK_DIV = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic mdc,
  output logic fall_tick,
  output logic rise_tick
);

  localparam int unsigned HALF = CLK_DIV / 2;
  localparam int CW = $clog2(CLK_DIV);

  logic [CW-1:0] cnt_q;
  logic          mdc_q;

  assign fall_tick = run && (cnt_q == '0);
  assign rise_tick = run && (cnt_q == CW'(HALF));
  assign mdc       = mdc_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else if (!run) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else begin
      cnt_q <= (cnt_q == CW'(CLK_DIV - 1)) ? '0 : cnt_q + 1'b1;
      if (fall_tick)      mdc_q <= 1'b0;
      else if (rise_tick) mdc_q <= 1'b1;
    end
  end

  // R9: two idle cycles in a row leave the clock low
  p_mdc_parked_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !$past(run)) |-> !mdc_q);

endmodule

// File: rtl/mdio_capture.sv
module mdio_capture #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  input  logic         shift_en,
  input  logic         din,
  output logic [W-1:0] q
);

  logic [W-1:0] sh_q;

  always_ff @(posedge clk) begin
    if (!rst_n || clear) sh_q <= '0;
    else if (shift_en)   sh_q <= {sh_q[W-2:0], din};
  end

  assign q = sh_q;

endmodule

// File: rtl/mdio_frame.sv
module mdio_frame
  import mdio_acc_pkg::*;
#(
  parameter logic [PHYNUM_W-1:0] PHY_ADDR = 5'd1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic                cmd_wr,
  input  logic [REGNUM_W-1:0] cmd_reg,
  input  logic [DATA_W-1:0]   cmd_data,
  input  logic                fall_tick,
  input  logic                rise_tick,
  input  logic                mdc,
  output logic                active,
  output logic                mdio_o,
  output logic                mdio_oe,
  output logic                sample_en,
  output logic                done
);

  logic [FRAME_BITS-1:0] sh_q;
  logic [CNT_W-1:0]      cnt_q;
  logic [POS_W-1:0]      pos_q;
  logic                  active_q, wr_q, out_q, oe_q, done_q;
  logic                  last_rise;

  assign last_rise = active_q && rise_tick && (pos_q == POS_W'(FRAME_BITS - 1))
                     && (cnt_q == CNT_W'(FRAME_BITS));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh_q     <= '0;
      cnt_q    <= '0;
      pos_q    <= '0;
      active_q <= 1'b0;
      wr_q     <= 1'b0;
      out_q    <= 1'b1;
      oe_q     <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start) begin
        active_q <= 1'b1;
        wr_q     <= cmd_wr;
        sh_q     <= build_frame(cmd_wr, PHY_ADDR, cmd_reg, cmd_data);
        cnt_q    <= '0;
        pos_q    <= '0;
      end else if (active_q) begin
        if (fall_tick) begin
          out_q <= sh_q[FRAME_BITS-1];
          sh_q  <= {sh_q[FRAME_BITS-2:0], 1'b1};
          oe_q  <= wr_q || (cnt_q < CNT_W'(RD_DRIVE_BITS));
          pos_q <= cnt_q[POS_W-1:0];
          cnt_q <= cnt_q + 1'b1;
        end
        if (last_rise) begin
          active_q <= 1'b0;
          done_q   <= 1'b1;
        end
      end
      if (done_q) begin
        oe_q  <= 1'b0;
        out_q <= 1'b1;
      end
    end
  end

  assign active    = active_q;
  assign mdio_o    = out_q;
  assign mdio_oe   = oe_q;
  assign done      = done_q;
  assign sample_en = active_q && rise_tick && !wr_q && (pos_q >= POS_W'(DATA_FIRST));

  // R6: line outputs only move while the management clock is low
  p_line_moves_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($changed(out_q) || $changed(oe_q)) |-> !mdc);

  // R4: during a read the line is released whenever turnaround/data bits are sampled
  p_read_released_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && rise_tick && !wr_q && (pos_q >= POS_W'(RD_DRIVE_BITS))) |-> !oe_q);

endmodule

// File: rtl/phy_mgmt_reg.sv
module phy_mgmt_reg
  import mdio_acc_pkg::*;
#(
  parameter int unsigned         CLK_DIV    = 64,
  parameter logic [PHYNUM_W-1:0] PHY_ADDR   = 5'd1,
  parameter int                  ADDR_W     = 8,
  parameter logic [ADDR_W-1:0]   REG_OFFSET = 8'h60
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              mdc,
  output logic              mdio_o,
  output logic              mdio_oe,
  input  logic              mdio_i
);

  logic              flag_q, wr_q, busy_q;
  logic [6:0]        rsvd_q;
  logic [7:0]        regsel_q;
  logic [DATA_W-1:0] data_q;

  logic accept, run, fall_tick, rise_tick, sample_en, done;
  logic [DATA_W-1:0] cap_data;

  assign accept = reg_we && (reg_addr == REG_OFFSET) && !busy_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag_q   <= 1'b0;
      wr_q     <= 1'b0;
      busy_q   <= 1'b0;
      rsvd_q   <= '0;
      regsel_q <= '0;
      data_q   <= '0;
    end else if (accept) begin
      flag_q   <= reg_wdata[31];
      wr_q     <= reg_wdata[31];
      rsvd_q   <= reg_wdata[30:24];
      regsel_q <= reg_wdata[23:16];
      data_q   <= reg_wdata[15:0];
      busy_q   <= 1'b1;
    end else if (done) begin
      busy_q <= 1'b0;
      flag_q <= !wr_q;
      if (!wr_q) data_q <= cap_data;
    end
  end

  assign reg_rdata = {flag_q, rsvd_q, regsel_q, data_q};

  mdc_gen #(.CLK_DIV(CLK_DIV)) u_mdc (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (run),
    .mdc       (mdc),
    .fall_tick (fall_tick),
    .rise_tick (rise_tick)
  );

  mdio_frame #(.PHY_ADDR(PHY_ADDR)) u_frame (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (accept),
    .cmd_wr    (reg_wdata[31]),
    .cmd_reg   (reg_wdata[16 +: REGNUM_W]),
    .cmd_data  (reg_wdata[15:0]),
    .fall_tick (fall_tick),
    .rise_tick (rise_tick),
    .mdc       (mdc),
    .active    (run),
    .mdio_o    (mdio_o),
    .mdio_oe   (mdio_oe),
    .sample_en (sample_en),
    .done      (done)
  );

  mdio_capture #(.W(DATA_W)) u_cap (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (accept),
    .shift_en (sample_en),
    .din      (mdio_i),
    .q        (cap_data)
  );

  // R2: a finished write leaves the flag at 0
  p_write_clears_flag_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(busy_q) && wr_q) |-> !flag_q);

  // R5: a finished read leaves the flag at 1
  p_read_sets_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(busy_q) && !wr_q) |-> flag_q);

  // R8: the command fields hold for the whole access
  p_cmd_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && $past(busy_q)) |-> ($stable(regsel_q) && $stable(wr_q) && $stable(rsvd_q)));

  // R9: the link is quiet whenever no access runs
  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |-> (!mdc && !mdio_oe));

endmodule

// File: tb/tb_phy_mgmt_reg.sv
module tb_phy_mgmt_reg;

  localparam int unsigned DIV  = 4;
  localparam logic [4:0]  PHYA = 5'h1D;
  localparam int          LAT  = 2 + 63 * DIV + DIV / 2;
  localparam int          NV   = 6;

  // {wr, regsel[7:0], data[15:0], phy response[15:0]}
  localparam logic [40:0] VEC [NV] = '{
    {1'b1, 8'h00, 16'h1340, 16'h0000},
    {1'b0, 8'h01, 16'hBEEF, 16'h796D},
    {1'b1, 8'h04, 16'h01E1, 16'h0000},
    {1'b0, 8'h09, 16'h0000, 16'h8001},
    {1'b1, 8'hE9, 16'hA5C3, 16'h0000},
    {1'b0, 8'hFF, 16'h1234, 16'h5AA5}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [7:0]  reg_addr = 8'h00;
  logic [31:0] reg_wdata = 32'h0;
  logic [31:0] reg_rdata;
  logic        mdc, mdio_o, mdio_oe;
  logic        mdio_i = 1'b1;

  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  phy_mgmt_reg #(.CLK_DIV(DIV), .PHY_ADDR(PHYA)) dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  // PHY model and line monitor
  logic [15:0] resp_q = 16'h0;
  logic [63:0] cap_bits = '0, cap_oe = '0;
  logic        mdc_d = 1'b0, oe_d = 1'b0, mo_d = 1'b1;
  int          rise_cnt = 0, last_rise = 0, per_min = 0, per_max = 0, cyc = 0, bad_move = 0;

  always @(posedge clk) begin
    cyc   <= cyc + 1;
    mdc_d <= mdc;
    oe_d  <= mdio_oe;
    mo_d  <= mdio_o;
    if (mdc && ((mdio_o !== mo_d) || (mdio_oe !== oe_d))) bad_move <= bad_move + 1;
    if (mdio_oe && !oe_d) begin
      rise_cnt <= 0;
      per_min  <= 100000;
      per_max  <= 0;
    end else begin
      if (mdc && !mdc_d) begin
        cap_bits <= {cap_bits[62:0], mdio_o};
        cap_oe   <= {cap_oe[62:0], mdio_oe};
        rise_cnt <= rise_cnt + 1;
        last_rise <= cyc;
        if (rise_cnt > 0) begin
          if (cyc - last_rise < per_min) per_min <= cyc - last_rise;
          if (cyc - last_rise > per_max) per_max <= cyc - last_rise;
        end
      end
      if (!mdc && mdc_d)
        mdio_i <= (rise_cnt >= 48 && rise_cnt <= 63) ? resp_q[15 - (rise_cnt - 48)] : 1'b1;
    end
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] exp_frame(input logic wr, input logic [4:0] rn, input logic [15:0] d);
    exp_frame = {32'hFFFF_FFFF, 2'b01, wr ? 2'b01 : 2'b10, PHYA, rn, wr ? 2'b10 : 2'b11, d};
  endfunction

  function automatic logic [63:0] oe_mask(input logic wr);
    oe_mask = wr ? {64{1'b1}} : {{46{1'b1}}, 18'b0};
  endfunction

  task automatic host_write(input logic [7:0] a, input logic [31:0] w);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = w;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic wait_flag(input logic want, output int n);
    n = 0;
    while (reg_rdata[31] !== want && n < 2000) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic summary;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    summary();
  end

  initial begin
    int n;
    logic [31:0] cmd;
    logic [63:0] m;
    repeat (3) @(negedge clk);
    chk("R1 word in reset", 64'(reg_rdata), 64'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 word after reset", 64'(reg_rdata), 64'h0);
    chk("R1 mdc/oe after reset", {62'b0, mdc, mdio_oe}, 64'h0);

    for (int v = 0; v < NV; v++) begin
      logic wr; logic [7:0] rs; logic [15:0] d, r;
      {wr, rs, d, r} = VEC[v];
      resp_q = r;
      cmd = {wr, 7'h2A, rs, d};
      host_write(8'h60, cmd);
      // R2 / R10: word reads back as written while running
      chk("R2 R10 readback during access", 64'(reg_rdata), 64'(cmd));
      wait_flag(!wr, n);
      chk(wr ? "R2 write completion cycles" : "R5 read completion cycles", 64'(n), 64'(LAT));
      if (wr) chk("R2 word after write", 64'(reg_rdata), 64'({1'b0, 7'h2A, rs, d}));
      else    chk("R5 word after read", 64'(reg_rdata), 64'({1'b1, 7'h2A, rs, r}));
      m = oe_mask(wr);
      chk(wr ? "R3 R10 write frame bits" : "R4 R10 read frame bits",
          cap_bits & m, exp_frame(wr, rs[4:0], d) & m);
      chk(wr ? "R3 drive enable" : "R4 release pattern", cap_oe, m);
      chk("R6 mdc period min", 64'(per_min), 64'(DIV));
      chk("R6 mdc period max", 64'(per_max), 64'(DIV));
      repeat (3) @(negedge clk);
    end

    // R7: other offset ignored
    cmd = reg_rdata;
    host_write(8'h64, 32'h8005_FFFF);
    repeat (20) @(negedge clk);
    chk("R7 word unchanged", 64'(reg_rdata), 64'(cmd));
    chk("R7 no frame started", {62'b0, mdc, mdio_oe}, 64'h0);

    // R8: second command during an access is dropped
    resp_q = 16'hFFFF;
    cmd = {1'b1, 7'h00, 8'h1E, 16'h3C3C};
    host_write(8'h60, cmd);
    repeat (100) @(negedge clk);
    host_write(8'h60, {1'b0, 7'h00, 8'h02, 16'h0000});
    chk("R8 word kept during access", 64'(reg_rdata), 64'(cmd));
    wait_flag(1'b0, n);
    chk("R8 completion time unchanged", 64'(n + 102), 64'(LAT));
    chk("R8 frame of first command", cap_bits, exp_frame(1'b1, 5'h1E, 16'h3C3C));
    chk("R8 final word", 64'(reg_rdata), 64'({1'b0, 7'h00, 8'h1E, 16'h3C3C}));

    // R9: idle line
    repeat (10) @(negedge clk);
    chk("R9 idle mdc/oe", {62'b0, mdc, mdio_oe}, 64'h0);
    chk("R6 line moved while mdc high", 64'(bad_move), 64'h0);
    summary();
  end

endmodule